// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one logic cell of a programmable array, controlled entirely by a configuration vector. It receives a set of routed signals and a small regional bus of feedback terms. From them it forms five AND terms, each of which may use any signal in true or complemented form. A per-term steering field then decides what each term does. A term can feed the OR sum, feed the auxiliary XOR input, act as the register clock enable, or be unused.

The OR sum can absorb a cascade input from the neighbouring cell and is passed on unchanged as the cascade output, so cells can be chained into wide sums. The sum then passes through a programmable XOR. Its second input is a constant 0 or 1, which selects polarity, or the XOR-steered terms, or the cell's own register output. The last choice turns the D register into a toggle or J/K-style element. The pin output is either the XOR result or the registered value. The cell also drives an inverted copy of one chosen term onto the foldback output.

The configuration is captured into internal registers on a load strobe and otherwise stays fixed.

Top module: `pld_macrocell`

## Requirements
- R1: While rst_ni is low, the configuration register and the data register are cleared. With an all-zero configuration, pin_o, cascade_o and foldback_o are all 0.
- R2: The term inputs are the vector {fb_bus_i, sw_i}, with sw_i in the low bits. Term t's mask occupies cfg bits [t*2*N_IN +: 2*N_IN]. Mask bit j (j < N_IN) requires input j to be 1, and mask bit N_IN+j requires input j to be 0. The term is the AND of all enabled literals, and a term with no literal enabled is 1.
- R3: Term t's 2-bit route field sits at cfg bit 10*N_IN+2t, with codes 00 unused, 01 OR sum, 10 XOR auxiliary and 11 clock enable. The OR sum is the OR of the terms routed 01, and a term with any other route adds nothing to it.
- R4: When the cascade-enable bit (cfg bit 10*N_IN+16) is 1, cascade_i is ORed into the sum; when it is 0, cascade_i has no effect. cascade_o always equals the sum.
- R5: The XOR-source field is 2 bits at cfg bit 10*N_IN+10. Its codes are 00 for constant 0, 01 for constant 1 (inverted sum), 10 for the OR of the terms routed 10 (0 if there are none), and 11 for the register output. The XOR result is the sum XOR the selected source.
- R6: When the output-select bit (cfg bit 10*N_IN+15) is 0, pin_o is the XOR result combinationally. When it is 1, pin_o is the register, which captures the XOR result on a rising clk_i edge.
- R7: If any term is routed 11, the register captures only on edges where the OR of those terms is 1 and holds otherwise. If no term is routed 11, it captures on every edge.
- R8: With XOR source 11, the register toggles on each enabled edge where the sum is 1 and holds where the sum is 0.
- R9: The 3-bit foldback-select field at cfg bit 10*N_IN+12 picks term k for values 0 to 4, and foldback_o is the inverse of term k. Values 5 to 7 drive foldback_o to 1.
- R10: cfg_i is captured only on a rising edge with cfg_load_i high; at other times changes on cfg_i do not affect any output.
- R11: Pulling rst_ni low clears the register and configuration at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Capture strobe for cfg_i |
| cfg_i | input | 10*N_IN+17 | Configuration vector |
| sw_i | input | N_SW | Routed array signals |
| fb_bus_i | input | N_FB | Regional foldback bus |
| cascade_i | input | 1 | Sum from the neighbouring cell |
| pin_o | output | 1 | Combinational or registered result |
| cascade_o | output | 1 | This cell's sum, including the cascade input |
| foldback_o | output | 1 | Inverted selected term |

## Verification
Some properties are checked on every cycle. These are that a set cascade input forces cascade_o when cascading is enabled, and that a constant-0 XOR source passes the sum unaltered. They also cover the register capturing its input only when enabled and holding otherwise, toggling in the T configuration, and the configuration staying put without a load strobe. Other behaviour can only be shown by the bench's scenarios, which compare every output against an independent model. This covers literal polarity and empty-term evaluation, exclusion of unrouted terms, and the auxiliary XOR terms. It also covers foldback selection including out-of-range codes, ignoring cfg_i while no load is pending, and an asynchronous reset in the middle of a run.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int unsigned NUM_PT = 5;

  typedef enum logic [1:0] {
    RT_OFF = 2'b00,
    RT_OR  = 2'b01,
    RT_XOR = 2'b10,
    RT_CE  = 2'b11
  } pt_route_e;

  typedef enum logic [1:0] {
    XS_ZERO = 2'b00,
    XS_ONE  = 2'b01,
    XS_TERM = 2'b10,
    XS_REG  = 2'b11
  } xor_src_e;
endpackage

// File: rtl/pld_mc_cfg_reg.sv
module pld_mc_cfg_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/pld_mc_pterm.sv
module pld_mc_pterm #(
  parameter int unsigned N_IN = 12
) (
  input  logic [N_IN-1:0]   in_i,
  input  logic [2*N_IN-1:0] mask_i,
  output logic              pt_o
);
  logic [N_IN-1:0] pos_ok, neg_ok;

  // an unmasked literal is don't-care; empty term is 1
  always_comb begin
    for (int j = 0; j < int'(N_IN); j++) begin
      pos_ok[j] = ~mask_i[j] | in_i[j];
      neg_ok[j] = ~mask_i[N_IN+j] | ~in_i[j];
    end
  end

  assign pt_o = (&pos_ok) & (&neg_ok);
endmodule

// File: rtl/pld_mc_steer.sv
module pld_mc_steer
  import pld_mc_pkg::*;
(
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic [2*NUM_PT-1:0] route_i,
  input  logic                casc_en_i,
  input  logic                cascade_i,
  input  logic [1:0]          xor_src_i,
  input  logic                q_i,
  input  logic [2:0]          fb_sel_i,
  output logic                sum_o,
  output logic                d_o,
  output logic                ce_o,
  output logic                foldback_o
);
  logic [NUM_PT-1:0] to_or, to_xor, to_ce, ce_used;
  logic              aux_x, xor_b;

  for (genvar t = 0; t < NUM_PT; t++) begin : g_route
    assign to_or[t]   = (route_i[2*t +: 2] == RT_OR)  & pt_i[t];
    assign to_xor[t]  = (route_i[2*t +: 2] == RT_XOR) & pt_i[t];
    assign ce_used[t] = (route_i[2*t +: 2] == RT_CE);
    assign to_ce[t]   = ce_used[t] & pt_i[t];
  end

  assign sum_o = (|to_or) | (casc_en_i & cascade_i);
  assign aux_x = |to_xor;
  assign ce_o  = (|ce_used) ? (|to_ce) : 1'b1;

  always_comb begin
    unique case (xor_src_e'(xor_src_i))
      XS_ZERO: xor_b = 1'b0;
      XS_ONE:  xor_b = 1'b1;
      XS_TERM: xor_b = aux_x;
      default: xor_b = q_i;
    endcase
  end

  assign d_o = sum_o ^ xor_b;

  always_comb begin
    foldback_o = 1'b1;
    for (int t = 0; t < int'(NUM_PT); t++)
      if (fb_sel_i == 3'(t)) foldback_o = ~pt_i[t];
  end

  // R4 / R5 combinational checks
  always_comb begin
    if (casc_en_i && cascade_i) a_r4_casc_forces: assert (sum_o);
    if (xor_src_e'(xor_src_i) == XS_ZERO) a_r5_zero_passes: assert (d_o == sum_o);
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int unsigned N_SW = 8,
  parameter int unsigned N_FB = 4,
  localparam int unsigned N_IN   = N_SW + N_FB,
  localparam int unsigned MASK_W = 2 * N_IN,
  localparam int unsigned BASE   = NUM_PT * MASK_W,
  localparam int unsigned CFG_W  = BASE + 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N_SW-1:0]  sw_i,
  input  logic [N_FB-1:0]  fb_bus_i,
  input  logic             cascade_i,
  output logic             pin_o,
  output logic             cascade_o,
  output logic             foldback_o
);
  localparam int unsigned OFS_ROUTE = BASE;
  localparam int unsigned OFS_XSRC  = BASE + 2 * NUM_PT;
  localparam int unsigned OFS_FBSEL = OFS_XSRC + 2;
  localparam int unsigned OFS_REGEN = OFS_FBSEL + 3;
  localparam int unsigned OFS_CASC  = OFS_REGEN + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic [N_IN-1:0]   in_vec;
  logic [NUM_PT-1:0] pt;
  logic              sum, d, ce, q;

  pld_mc_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .d_i    (cfg_i),
    .q_o    (cfg_q)
  );

  assign in_vec = {fb_bus_i, sw_i};

  for (genvar t = 0; t < NUM_PT; t++) begin : g_pt
    pld_mc_pterm #(.N_IN(N_IN)) u_pt (
      .in_i   (in_vec),
      .mask_i (cfg_q[t*MASK_W +: MASK_W]),
      .pt_o   (pt[t])
    );
  end

  pld_mc_steer u_steer (
    .pt_i       (pt),
    .route_i    (cfg_q[OFS_ROUTE +: 2*NUM_PT]),
    .casc_en_i  (cfg_q[OFS_CASC]),
    .cascade_i  (cascade_i),
    .xor_src_i  (cfg_q[OFS_XSRC +: 2]),
    .q_i        (q),
    .fb_sel_i   (cfg_q[OFS_FBSEL +: 3]),
    .sum_o      (sum),
    .d_o        (d),
    .ce_o       (ce),
    .foldback_o (foldback_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q <= 1'b0;
    else if (ce)  q <= d;
  end

  assign pin_o     = cfg_q[OFS_REGEN] ? q : d;
  assign cascade_o = sum;

  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce |=> (q == $past(d)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce |=> $stable(q));
  a_r8_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_src_e'(cfg_q[OFS_XSRC +: 2]) == XS_REG && ce && sum) |=> (q != $past(q)));
  a_r4_casc_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[OFS_CASC] && cascade_i) |-> cascade_o);
endmodule

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
module sim_pld_macrocell;
  localparam int N_SW = 8;
  localparam int N_FB = 4;
  localparam int N_IN = N_SW + N_FB;
  localparam int MW   = 2 * N_IN;
  localparam int B    = 5 * MW;
  localparam int CW   = B + 17;

  logic clk_i = 1'b0, rst_ni = 1'b0, cfg_load_i = 1'b0, cascade_i = 1'b0;
  logic [CW-1:0]   cfg_i = '0;
  logic [N_SW-1:0] sw_i = '0;
  logic [N_FB-1:0] fb_bus_i = '0;
  logic pin_o, cascade_o, foldback_o;

  pld_macrocell #(.N_SW(N_SW), .N_FB(N_FB)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .cfg_i(cfg_i),
    .sw_i(sw_i), .fb_bus_i(fb_bus_i), .cascade_i(cascade_i),
    .pin_o(pin_o), .cascade_o(cascade_o), .foldback_o(foldback_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct { logic pin; logic casc; logic fb; string tag; } exp_t;
  exp_t  sb_q[$];
  event  chk_ev;
  int    checks = 0, failures = 0;
  bit    done = 1'b0;

  logic [CW-1:0] cfg_m = '0, cfg_n = '0;
  logic          q_m = 1'b0;

  // reference model from the requirements
  task automatic model(input logic [CW-1:0] c, input logic [N_SW-1:0] s,
                       input logic [N_FB-1:0] f, input logic ci, input logic q,
                       output logic pin, output logic co, output logic fbo,
                       output logic d, output logic ce);
    logic [N_IN-1:0] iv;
    logic [4:0] pt;
    logic sum, xt, ce_any, ce_v, xb;
    logic [1:0] r, xs;
    logic [2:0] fs;
    iv = {f, s};
    sum = 0; xt = 0; ce_any = 0; ce_v = 0;
    for (int t = 0; t < 5; t++) begin
      pt[t] = 1'b1;
      for (int j = 0; j < N_IN; j++) begin
        if (c[t*MW+j] && !iv[j]) pt[t] = 1'b0;
        if (c[t*MW+N_IN+j] && iv[j]) pt[t] = 1'b0;
      end
      r = c[B+2*t +: 2];
      if (r == 2'b01) sum |= pt[t];
      if (r == 2'b10) xt |= pt[t];
      if (r == 2'b11) begin ce_any = 1; ce_v |= pt[t]; end
    end
    sum |= c[B+16] & ci;
    xs = c[B+10 +: 2];
    xb = (xs == 2'b00) ? 1'b0 : (xs == 2'b01) ? 1'b1 : (xs == 2'b10) ? xt : q;
    d = sum ^ xb;
    ce = ce_any ? ce_v : 1'b1;
    fs = c[B+12 +: 3];
    fbo = (fs < 3'd5) ? ~pt[fs] : 1'b1;
    pin = c[B+15] ? q : d;
    co = sum;
  endtask

  task automatic push(input logic p, input logic c, input logic f, input string tag);
    exp_t e;
    e.pin = p; e.casc = c; e.fb = f; e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
  endtask

  // monitor: pops expectations, samples 2 ns after the drive point
  initial begin
    forever begin
      @(chk_ev);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (pin_o !== e.pin || cascade_o !== e.casc || foldback_o !== e.fb) begin
          failures++;
          $display("FAIL %s: got pin=%b casc=%b fb=%b expected pin=%b casc=%b fb=%b",
                   e.tag, pin_o, cascade_o, foldback_o, e.pin, e.casc, e.fb);
        end
      end
    end
  end

  task automatic step(input logic [N_SW-1:0] s, input logic [N_FB-1:0] f,
                      input logic ci, input string tag);
    logic p, co, fbo, d, ce;
    @(negedge clk_i);
    sw_i = s; fb_bus_i = f; cascade_i = ci; cfg_load_i = 1'b0;
    model(cfg_m, s, f, ci, q_m, p, co, fbo, d, ce);
    push(p, co, fbo, tag);
    @(posedge clk_i);
    if (ce) q_m = d;
  endtask

  task automatic load(input logic [CW-1:0] c);
    logic p, co, fbo, d, ce;
    @(negedge clk_i);
    cfg_i = c; cfg_load_i = 1'b1;
    model(cfg_m, sw_i, fb_bus_i, cascade_i, q_m, p, co, fbo, d, ce);
    @(posedge clk_i);
    if (ce) q_m = d;
    cfg_m = c;
  endtask

  task automatic cfg_clear(); cfg_n = '0; endtask
  task automatic lit(input int t, input int j, input bit neg);
    cfg_n[t*MW + (neg ? N_IN : 0) + j] = 1'b1;
  endtask
  task automatic route(input int t, input logic [1:0] r); cfg_n[B+2*t +: 2] = r; endtask
  task automatic mode(input logic [1:0] xs, input logic [2:0] fs,
                      input logic reg_en, input logic casc_en);
    cfg_n[B+10 +: 2] = xs; cfg_n[B+12 +: 3] = fs;
    cfg_n[B+15] = reg_en; cfg_n[B+16] = casc_en;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #3; push(1'b0, 1'b0, 1'b0, "R1 reset");
    #10; rst_ni = 1'b1;
    step(8'hFF, 4'hF, 1'b1, "R1 zero cfg");

    // R2/R3: t0 = sw0&sw1, t1 = ~sw2, both to OR
    cfg_clear(); lit(0, 0, 0); lit(0, 1, 0); lit(1, 2, 1);
    route(0, 2'b01); route(1, 2'b01); mode(2'b00, 3'd0, 0, 0);
    load(cfg_n);
    step(8'h07, 4'h0, 0, "R2 both true literals");
    step(8'h05, 4'h0, 0, "R2 literal missing");
    step(8'h00, 4'h0, 0, "R2 complement literal");
    step(8'h06, 4'h0, 1, "R3 neither term");

    // R2 empty term routed to OR
    cfg_clear(); route(2, 2'b01); mode(2'b00, 3'd2, 0, 0);
    load(cfg_n);
    step(8'h00, 4'h0, 0, "R2 empty term is one");

    // R3 unused term excluded
    cfg_clear(); route(0, 2'b00); lit(1, 3, 0); route(1, 2'b01);
    load(cfg_n);
    step(8'h00, 4'h0, 0, "R3 off term excluded");
    step(8'h08, 4'h0, 0, "R3 routed term");

    // R4 cascade
    cfg_clear(); mode(2'b00, 3'd0, 0, 1);
    load(cfg_n);
    step(8'h00, 4'h0, 1, "R4 cascade in");
    step(8'h00, 4'h0, 0, "R4 cascade low");
    cfg_clear(); mode(2'b00, 3'd0, 0, 0);
    load(cfg_n);
    step(8'h00, 4'h0, 1, "R4 cascade disabled ignored");

    // R5 polarity and aux term
    cfg_clear(); lit(1, 3, 0); route(1, 2'b01); mode(2'b01, 3'd0, 0, 0);
    load(cfg_n);
    step(8'h08, 4'h0, 0, "R5 inverted high");
    step(8'h00, 4'h0, 0, "R5 inverted low");
    cfg_clear(); lit(1, 3, 0); route(1, 2'b01); lit(3, N_SW, 0); route(3, 2'b10);
    mode(2'b10, 3'd0, 0, 0);
    load(cfg_n);
    step(8'h08, 4'h1, 0, "R5 aux term xor");
    step(8'h08, 4'h0, 0, "R5 aux term zero");
    step(8'h00, 4'h1, 0, "R5 aux only");

    // R6 registered D
    cfg_clear(); lit(0, 0, 0); route(0, 2'b01); mode(2'b00, 3'd0, 1, 0);
    load(cfg_n);
    step(8'h01, 4'h0, 0, "R6 reg stage");
    step(8'h00, 4'h0, 0, "R6 reg lag one");
    step(8'h01, 4'h0, 0, "R6 reg lag zero");
    step(8'h01, 4'h0, 0, "R6 reg lag one again");

    // R7 clock enable from sw7
    route(4, 2'b11); lit(4, 7, 0);
    load(cfg_n);
    step(8'h00, 4'h0, 0, "R7 ce low hold");
    step(8'h00, 4'h0, 0, "R7 still held");
    step(8'h80, 4'h0, 0, "R7 ce high capture");
    step(8'h00, 4'h0, 0, "R7 captured zero");

    // R8 toggle
    cfg_clear(); lit(0, 0, 0); route(0, 2'b01); mode(2'b11, 3'd0, 1, 0);
    load(cfg_n);
    step(8'h01, 4'h0, 0, "R8 toggle a");
    step(8'h01, 4'h0, 0, "R8 toggle b");
    step(8'h00, 4'h0, 0, "R8 hold");
    step(8'h01, 4'h0, 0, "R8 toggle c");
    step(8'h00, 4'h0, 0, "R8 final");

    // R9 foldback
    cfg_clear(); lit(1, 3, 0); mode(2'b00, 3'd1, 0, 0);
    load(cfg_n);
    step(8'h08, 4'h0, 0, "R9 fb term high");
    step(8'h00, 4'h0, 0, "R9 fb term low");
    mode(2'b00, 3'd3, 0, 0);
    load(cfg_n);
    step(8'h00, 4'h0, 0, "R9 fb empty term");
    mode(2'b00, 3'd6, 0, 0);
    load(cfg_n);
    step(8'h08, 4'h0, 0, "R9 fb out of range");

    // R10 cfg_i ignored without load
    cfg_i = ~cfg_m;
    step(8'h08, 4'h0, 1, "R10 cfg ignored a");
    step(8'h00, 4'hF, 1, "R10 cfg ignored b");

    // R11 async reset mid-run with registered output set
    cfg_clear(); mode(2'b01, 3'd0, 1, 0);
    load(cfg_n);
    step(8'h00, 4'h0, 0, "R11 prime register");
    step(8'h00, 4'h0, 0, "R11 register high");
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    q_m = 1'b0; cfg_m = '0;
    push(1'b0, 1'b0, 1'b0, "R11 async clear");
    #1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(8'hFF, 4'hF, 1, "R11 stays cleared");

    @(negedge clk_i);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule